// File: doc/BRIEF.md
# 64-Point Trellis Group Encoder

This block is the inner coded-modulation front end for the 64-point constellation mode of a cable downstream transmitter. It accepts one 28-bit trellis group per handshake: four 7-bit code symbols, where the first two belong to stream A and the last two to stream B. Each group is split into uncoded bits and four coded bits per stream. The coded bits of A and B pass together through a two-input differential precoder that makes the result invariant to 90-degree carrier rotation. Each precoded 4-bit stream then goes through its own 16-state rate-1/2 convolutional coder, punctured to rate 4/5.

Every group produces five 6-bit labels, one per clock cycle, with a valid strobe. A constellation mapper downstream turns each label into a point. A label carries two uncoded A bits, one coded A bit, two uncoded B bits and one coded B bit. The input is back-pressured, so each group takes exactly five output cycles. A new group can be taken during the last label of the previous one, which leaves no gap between groups.

Top module: `qam64_tcm_encoder`

## Requirements
- R1: Synchronous active-high reset empties the output (out_valid low, in_ready high) and clears the precoder state and both coder shift registers to zero. The group accepted first after reset is encoded from that zero state.
- R2: A group is accepted on a rising edge where in_valid and in_ready are both high. Exactly five labels (beats 0 to 4) follow on consecutive cycles, starting in the cycle after acceptance.
- R3: in_ready is low while beats 0 to 3 of a group are on the output and high during beat 4 and when idle. Back-to-back groups therefore leave no idle cycle between them.
- R4: in_group[27:21] is A symbol 1, [20:14] is A symbol 2, [13:7] is B symbol 1 and [6:0] is B symbol 2. For each stream, with s1/s2 its two symbols (bit 0 the LSB), the uncoded (lo, hi) pair of beat k is: k0 (s1[0], s1[1]), k1 (s1[2], s1[3]), k2 (s1[4], s1[5]), k3 (s1[6], s2[0]), k4 (s2[1], s2[2]). The label layout is out_label[5]=A hi, [4]=A lo, [2]=B hi, [1]=B lo.
- R5: The coded input bits of each stream are s2[3], s2[4], s2[5], s2[6], taken in that time order (j=0..3). For each j, with w the A bit and z the B bit, the precoder computes t = z&(x^y), x' = w^x^t, y' = z^w^y^t, where x and y are its previous outputs. x' feeds coder A and y' feeds coder B.
- R6: Each coder is non-systematic with generators 1+D^2+D^4 and 1+D+D^2+D^3+D^4 (octal 25 and 37). D^1 is the previous input bit.
- R7: Puncturing keeps the second-generator bit for all four inputs and the first-generator bit only for the fourth. The serial order is G1 before G2 for each input, which gives G2(0), G2(1), G2(2), G1(3), G2(3). The n-th serial bit of coder A is out_label[3] of beat n, and the n-th of coder B is out_label[0].
- R8: out_label is all zeros in any cycle where out_valid is low.
- R9: Precoder and coder states carry over from group to group and are held unchanged through idle cycles between groups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A trellis group is offered |
| in_ready | output | 1 | The group on in_group is taken at this edge |
| in_group | input | 28 | Four 7-bit symbols: A1, A2, B1, B2 from MSB down |
| out_valid | output | 1 | out_label holds a beat |
| out_label | output | 6 | Symbol label: A hi, A lo, A coded, B hi, B lo, B coded |

## Verification
The assertions assume that in_valid changes only between edges and that the source never drops a group it has offered while in_ready is low. The stimulus changes inputs only on falling edges and raises in_valid only in a cycle where it sees in_ready high, so every offer is taken at the next edge. The beat counter in the checker is restarted only by an accepted group, so the run-length and ready-timing properties hold because offers are never placed mid-group. The stimulus sweeps all 256 combinations of the eight coded bits, both back to back and with idle gaps, and repeats a short run after a reset issued mid-stream.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

    localparam int SYM_W   = 7;
    localparam int GRP_W   = 4 * SYM_W;
    localparam int PAIR_W  = 2 * SYM_W;
    localparam int BEATS   = 5;
    localparam int CODED_N = 4;
    localparam int MEM     = 4;
    localparam int LBL_W   = 6;
    localparam int CNT_W   = $clog2(BEATS);

    // generator taps, bit i multiplies D^i
    localparam logic [MEM:0] G1_POLY = 5'o25;
    localparam logic [MEM:0] G2_POLY = 5'o37;
    // keep masks, bit j = j-th coded input in time
    localparam logic [CODED_N-1:0] G1_KEEP = 4'b1000;
    localparam logic [CODED_N-1:0] G2_KEEP = 4'b1111;

    typedef logic [LBL_W-1:0] label_t;

    typedef struct packed {
        logic [BEATS-1:0]   hi;
        logic [BEATS-1:0]   lo;
        logic [CODED_N-1:0] cod;
    } half_t;

    // position inside a 14-bit pair {s1, s2} of the uncoded bit of beat k
    function automatic int unc_pos(input int k, input bit hi);
        int p;
        case (k)
            0: p = hi ? 8  : 7;
            1: p = hi ? 10 : 9;
            2: p = hi ? 12 : 11;
            3: p = hi ? 0  : 13;
            default: p = hi ? 2 : 1;
        endcase
        return p;
    endfunction

    // position inside a pair of the coded bit taken at time j
    function automatic int cod_pos(input int j);
        return 3 + j;
    endfunction

    // one coder output: st[0] is the most recent past input
    function automatic logic conv_bit(input logic [MEM:0] poly,
                                      input logic [MEM-1:0] st,
                                      input logic x);
        return ^(poly & {st, x});
    endfunction

    // one precoder step, returns {x', y'}
    function automatic logic [1:0] precode_step(input logic w, input logic z,
                                                input logic xp, input logic yp);
        logic t;
        t = z & (xp ^ yp);
        return {w ^ xp ^ t, z ^ w ^ yp ^ t};
    endfunction

endpackage

// File: rtl/tcm_parser.sv
module tcm_parser
    import tcm_pkg::*;
(
    input  logic [GRP_W-1:0] grp,
    output half_t [1:0]      hv
);
    // hv[0] is stream A (upper pair), hv[1] is stream B (lower pair)
    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [PAIR_W-1:0] pair;
        assign pair = grp[GRP_W-1-h*PAIR_W -: PAIR_W];
        for (genvar k = 0; k < BEATS; k++) begin : g_unc
            assign hv[h].lo[k] = pair[unc_pos(k, 1'b0)];
            assign hv[h].hi[k] = pair[unc_pos(k, 1'b1)];
        end
        for (genvar j = 0; j < CODED_N; j++) begin : g_cod
            assign hv[h].cod[j] = pair[cod_pos(j)];
        end
    end
endmodule

// File: rtl/tcm_precoder.sv
module tcm_precoder
    import tcm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               adv,
    input  logic [CODED_N-1:0] w,
    input  logic [CODED_N-1:0] z,
    output logic [CODED_N-1:0] x,
    output logic [CODED_N-1:0] y
);
    logic x_q, y_q;

    always_comb begin
        logic xp, yp;
        logic [1:0] r;
        xp = x_q;
        yp = y_q;
        x  = '0;
        y  = '0;
        for (int j = 0; j < CODED_N; j++) begin
            r    = precode_step(w[j], z[j], xp, yp);
            x[j] = r[1];
            y[j] = r[0];
            xp   = r[1];
            yp   = r[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q <= 1'b0;
            y_q <= 1'b0;
        end else if (adv) begin
            x_q <= x[CODED_N-1];
            y_q <= y[CODED_N-1];
        end
    end
endmodule

// File: rtl/tcm_punct_coder.sv
module tcm_punct_coder
    import tcm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               adv,
    input  logic [CODED_N-1:0] d,
    output logic [BEATS-1:0]   ser
);
    logic [MEM-1:0] st_q, st_n;

    always_comb begin
        logic [MEM-1:0] st;
        logic [CNT_W-1:0] idx;
        st  = st_q;
        idx = '0;
        ser = '0;
        for (int j = 0; j < CODED_N; j++) begin
            if (G1_KEEP[j]) begin
                ser[idx] = conv_bit(G1_POLY, st, d[j]);
                idx      = idx + 1'b1;
            end
            if (G2_KEEP[j]) begin
                ser[idx] = conv_bit(G2_POLY, st, d[j]);
                idx      = idx + 1'b1;
            end
            st = {st[MEM-2:0], d[j]};
        end
        st_n = st;
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else if (adv)
            st_q <= st_n;
    end
endmodule

// File: rtl/qam64_tcm_encoder.sv
module qam64_tcm_encoder
    import tcm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [GRP_W-1:0] in_group,
    output logic             out_valid,
    output logic [LBL_W-1:0] out_label
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

    half_t [1:0]        hv;
    logic [CODED_N-1:0] px, py;
    logic [BEATS-1:0]   ser [2];
    label_t             lbl [BEATS];
    label_t             lbl_q [BEATS];
    logic [CNT_W-1:0]   beat_q;
    logic               busy_q;
    logic               accept;

    assign in_ready = !busy_q || (beat_q == LAST);
    assign accept   = in_valid && in_ready;

    tcm_parser u_parse (
        .grp (in_group),
        .hv  (hv)
    );

    tcm_precoder u_prec (
        .clk (clk),
        .rst (rst),
        .adv (accept),
        .w   (hv[0].cod),
        .z   (hv[1].cod),
        .x   (px),
        .y   (py)
    );

    for (genvar h = 0; h < 2; h++) begin : g_coder
        tcm_punct_coder u_cc (
            .clk (clk),
            .rst (rst),
            .adv (accept),
            .d   (h == 0 ? px : py),
            .ser (ser[h])
        );
    end

    for (genvar k = 0; k < BEATS; k++) begin : g_lbl
        assign lbl[k] = {hv[0].hi[k], hv[0].lo[k], ser[0][k],
                         hv[1].hi[k], hv[1].lo[k], ser[1][k]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            beat_q <= '0;
            for (int k = 0; k < BEATS; k++) lbl_q[k] <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            beat_q <= '0;
            for (int k = 0; k < BEATS; k++) lbl_q[k] <= lbl[k];
        end else if (busy_q) begin
            if (beat_q == LAST) begin
                busy_q <= 1'b0;
                beat_q <= '0;
            end else begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    assign out_valid = busy_q;
    assign out_label = busy_q ? lbl_q[beat_q] : '0;
endmodule

// File: rtl/qam64_tcm_encoder_chk.sv
module qam64_tcm_encoder_chk
    import tcm_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic [LBL_W-1:0] out_label
);
    localparam logic [2:0] LASTB = 3'(BEATS - 1);
    logic [2:0] beat;

    always_ff @(posedge clk) begin
        if (rst)
            beat <= '0;
        else if (in_valid && in_ready)
            beat <= '0;
        else if (out_valid)
            beat <= beat + 3'd1;
    end

    // R2
    start_run_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);
    // R2
    run_len_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (beat <= LASTB));
    // R2
    no_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && beat < LASTB) |=> out_valid);
    // R3
    hold_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && beat != LASTB) |-> !in_ready);
    // R3
    last_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && beat == LASTB) |-> in_ready);
    // R1
    idle_ready_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready);
    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_label == '0));
endmodule

bind qam64_tcm_encoder qam64_tcm_encoder_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_label (out_label)
);

// File: tb/qam64_tcm_encoder_test.sv
`timescale 1ns/1ps
module qam64_tcm_encoder_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [27:0] in_group = '0;
    logic        in_ready;
    logic        out_valid;
    logic [5:0]  out_label;

    int errors = 0;
    int checks = 0;
    logic [5:0] expq[$];
    string ctag = "R5 R6 R7";

    // reference state: precoder outputs and coder memories (m[1] most recent)
    logic mx, my;
    logic ma [1:4];
    logic mb [1:4];

    always #2.5 clk = ~clk;

    qam64_tcm_encoder uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_group  (in_group),
        .out_valid (out_valid),
        .out_label (out_label)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        mx = 0; my = 0;
        for (int i = 1; i <= 4; i++) begin ma[i] = 0; mb[i] = 0; end
    endtask

    task automatic run_coder(input logic [3:0] d, inout logic m [1:4], output logic [4:0] s);
        int n;
        logic g1, g2;
        n = 0;
        s = '0;
        for (int j = 0; j < 4; j++) begin
            g1 = d[j] ^ m[2] ^ m[4];
            g2 = d[j] ^ m[1] ^ m[2] ^ m[3] ^ m[4];
            if (j == 3) begin s[n] = g1; n++; end
            s[n] = g2; n++;
            m[4] = m[3]; m[3] = m[2]; m[2] = m[1]; m[1] = d[j];
        end
    endtask

    task automatic model_group(input logic [27:0] g);
        logic [6:0] a1, a2, b1, b2;
        logic [3:0] w, z, xs, ys;
        logic [4:0] u, v, alo, ahi, blo, bhi;
        logic t;
        {a1, a2, b1, b2} = g;
        w = a2[6:3];
        z = b2[6:3];
        for (int j = 0; j < 4; j++) begin
            t = z[j] & (mx ^ my);
            xs[j] = w[j] ^ mx ^ t;
            ys[j] = z[j] ^ w[j] ^ my ^ t;
            mx = xs[j];
            my = ys[j];
        end
        run_coder(xs, ma, u);
        run_coder(ys, mb, v);
        alo = {a2[1], a1[6], a1[4], a1[2], a1[0]};
        ahi = {a2[2], a2[0], a1[5], a1[3], a1[1]};
        blo = {b2[1], b1[6], b1[4], b1[2], b1[0]};
        bhi = {b2[2], b2[0], b1[5], b1[3], b1[1]};
        for (int k = 0; k < 5; k++)
            expq.push_back({ahi[k], alo[k], u[k], bhi[k], blo[k], v[k]});
    endtask

    function automatic logic [27:0] make_group(input int n, input int salt);
        logic [9:0] ua, ub;
        logic [7:0] nb;
        nb = 8'(n);
        ua = 10'(n * 181 + salt * 73 + 29);
        ub = 10'(n * 97 + salt * 211 + 3);
        return {ua[6:0], nb[3:0], ua[9:7], ub[6:0], nb[7:4], ub[9:7]};
    endfunction

    task automatic monitor();
        logic [5:0] e;
        chk(in_ready == (expq.size() <= 1), "R3", in_ready, expq.size() <= 1);
        if (out_valid) begin
            if (expq.size() == 0) begin
                chk(0, "R2", 1, 0);
            end else begin
                e = expq.pop_front();
                chk({out_label[5:4], out_label[2:1]} == {e[5:4], e[2:1]}, "R4",
                    out_label, e);
                chk({out_label[3], out_label[0]} == {e[3], e[0]}, ctag, out_label, e);
            end
        end else begin
            chk(out_label == 6'd0, "R8", out_label, 0);
            chk(expq.size() == 0, "R2", 0, 1);
        end
    endtask

    task automatic run_phase(input int count, input int salt, input bit gaps);
        int n;
        int cyc;
        n = 0;
        cyc = 0;
        while (n < count) begin
            @(negedge clk);
            monitor();
            cyc++;
            if (in_ready && !(gaps && ((cyc * 7 + n) % 4 == 0))) begin
                in_group = make_group(n, salt);
                in_valid = 1'b1;
                model_group(in_group);
                n++;
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            monitor();
            in_valid = 1'b0;
        end
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state after reset
        chk(out_valid == 1'b0, "R1", out_valid, 0);
        chk(in_ready == 1'b1, "R1", in_ready, 1);
        chk(out_label == 6'd0, "R1", out_label, 0);
        rst = 1'b0;

        ctag = "R5 R6 R7";
        run_phase(256, 1, 1'b0);
        drain();

        ctag = "R9";
        run_phase(256, 2, 1'b1);
        drain();

        // mid-stream reset, then encode from the zero state
        ctag = "R5 R6 R7";
        run_phase(3, 3, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        expq.delete();
        model_reset();
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", out_valid, 0);
        chk(in_ready == 1'b1, "R1", in_ready, 1);
        rst = 1'b0;
        ctag = "R1";
        run_phase(16, 4, 1'b0);
        drain();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule